// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry/Link Status

This block is a purely combinational shifter for a minicomputer-style datapath. It moves a 16-bit or 32-bit operand left or right by a count. The move can be logical (zero fill), arithmetic (sign fill on the right, overflow detection on the left) or a rotate. Beside the shifted value it returns one status bit. The surrounding keys logic copies that bit into both the carry and the link condition bits (key bits 15 and 13, mask octal 0120000). Because every shift operation writes the bit to a definite value, the old carry and link values never carry through a shift.

A width select picks 16-bit mode or 32-bit mode. In 16-bit mode the unit uses the low half of the operand and zero-extends its result. Counts larger than the width follow a separate rule for each kind of operation. Rotate counts are folded into the range 1 to width. Instruction decode, the register file and the rest of the keys register are outside this block.

Top module: `srf_shift_unit`

## Requirements
- R1: `cl_flag_o` depends only on the present inputs. Two consecutive operations with different inputs produce independent flag values, so a flag that was set is cleared when the next operation calls for a clear.
- R2: For logical right shift (op 1) and arithmetic right shift (op 3) with count n in 1..W, the flag equals operand bit n-1 (LSB is bit 0).
- R3: For logical left shift (op 0) with count n in 1..W, the flag equals operand bit W-n.
- R4: For a logical shift (op 0 or 1) with count greater than W, the result is zero and the flag is clear.
- R5: For an arithmetic right shift with count greater than W, the result is all ones and the flag is set if the operand sign bit is 1. Otherwise the result is zero and the flag is clear.
- R6: For an arithmetic left shift (op 2) with count n in 1..W-1, the flag is set exactly when the top n+1 operand bits are not all equal. With n of W or more, the result is zero and the flag is set exactly when the operand is non-zero.
- R7: Logical shifts fill vacated positions with zeros. An arithmetic right shift fills them with the sign bit. An arithmetic left shift fills with zeros.
- R8: For a rotate left (op 4) or rotate right (op 5), the effective count is m = ((n-1) mod W)+1, and a count of 0 gives m = W. The result is the operand rotated by m. The flag is operand bit W-m for a left rotate and operand bit m-1 for a right rotate.
- R9: For ops 0 to 3, a count of zero returns the operand unchanged with the flag clear.
- R10: `wide_i`=1 selects W=32. `wide_i`=0 selects W=16: the unit works on operand bits 15:0, ignores bits 31:16, and drives result bits 31:16 to zero.
- R11: Op codes 6 and 7 return the operand unchanged (within the selected width) with the flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand; only bits 15:0 are used in 16-bit mode |
| count_i | input | 8 | Unsigned shift count |
| op_i | input | 3 | Operation: 0 LSL, 1 LSR, 2 ASL, 3 ASR, 4 ROL, 5 ROR, 6/7 pass |
| wide_i | input | 1 | 1 = 32-bit mode, 0 = 16-bit mode |
| result_o | output | 32 | Shifted value, zero-extended in 16-bit mode |
| cl_flag_o | output | 1 | Shift status for the carry and link key bits |

## Verification
The bench builds the unit with its defaults: a 32-bit wide lane, a 16-bit narrow lane, and an 8-bit count. Counts up to 255 exceed both widths by a large margin, so the over-range rules of every operation and the rotate fold wraparound are reachable in both modes. Random operands are mixed with small sign-extended values, so an arithmetic left shift both overflows and stays clean. Directed cases cover a count of zero, a count equal to the width, and a count one above the width.

// File: rtl/srf_pkg.sv
package srf_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LSL  = 3'd0,
        OP_LSR  = 3'd1,
        OP_ASL  = 3'd2,
        OP_ASR  = 3'd3,
        OP_ROL  = 3'd4,
        OP_ROR  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } shop_e;

    typedef struct packed {
        logic zero;   // count is zero
        logic over;   // count exceeds lane width
    } cnt_class_t;

    function automatic logic op_is_rotate(shop_e op);
        return (op == OP_ROL) || (op == OP_ROR);
    endfunction

    function automatic logic op_is_shift(shop_e op);
        return (op == OP_LSL) || (op == OP_LSR) || (op == OP_ASL) || (op == OP_ASR);
    endfunction

    function automatic logic op_is_logical(shop_e op);
        return (op == OP_LSL) || (op == OP_LSR);
    endfunction

endpackage

// File: rtl/srf_count_fold.sv
module srf_count_fold
    import srf_pkg::*;
#(
    parameter int W     = 32,
    parameter int CNT_W = 8,
    localparam int LW   = $clog2(W),
    localparam int SW   = LW + 1
) (
    input  logic [CNT_W-1:0] cnt,
    output cnt_class_t       cls,
    output logic [SW-1:0]    sh_amt,
    output logic [SW-1:0]    rot_amt
);
    localparam logic [CNT_W-1:0] W_CNT = CNT_W'(W);

    logic [CNT_W-1:0] cnt_m1;

    always_comb begin
        cls.zero = (cnt == '0);
        cls.over = (cnt > W_CNT);
        // clamp shift distance to the lane width
        sh_amt   = cls.over ? SW'(W) : SW'(cnt);
        // fold rotate count into 1..W (W is a power of two)
        cnt_m1   = cnt - CNT_W'(1);
        rot_amt  = SW'(cnt_m1[LW-1:0]) + SW'(1);
    end

    always_comb begin
        p_rot_range_r8: assert (rot_amt >= SW'(1) && rot_amt <= SW'(W))
            else $error("rotate fold out of range");
        p_clamp_r4: assert (!cls.over || sh_amt == SW'(W))
            else $error("over-range count not clamped");
    end

endmodule

// File: rtl/srf_lane.sv
module srf_lane
    import srf_pkg::*;
#(
    parameter int W     = 32,
    parameter int CNT_W = 8,
    localparam int LW   = $clog2(W),
    localparam int SW   = LW + 1
) (
    input  logic [W-1:0]     x,
    input  logic [CNT_W-1:0] cnt,
    input  shop_e            op,
    output logic [W-1:0]     res,
    output logic             st
);
    localparam logic [SW-1:0] WV  = SW'(W);
    localparam logic [SW-1:0] ONE = SW'(1);

    cnt_class_t    cls;
    logic [SW-1:0] sh;
    logic [SW-1:0] rm;

    srf_count_fold #(.W(W), .CNT_W(CNT_W)) u_fold (
        .cnt     (cnt),
        .cls     (cls),
        .sh_amt  (sh),
        .rot_amt (rm)
    );

    logic          sign;
    logic [LW-1:0] i_rsh, i_lsh, i_rol, i_ror;
    logic [W-1:0]  lsr_v, lsl_v, asr_v, rol_v, ror_v;
    logic [W-1:0]  asl_hi, asl_lm;
    logic          asl_bad;

    // candidate results for every operation
    always_comb begin
        sign    = x[W-1];
        i_rsh   = LW'(sh - ONE);
        i_lsh   = LW'(WV - sh);
        i_rol   = LW'(WV - rm);
        i_ror   = LW'(rm - ONE);
        lsr_v   = x >> sh;
        lsl_v   = x << sh;
        asr_v   = $signed(x) >>> sh;
        rol_v   = (x << rm) | (x >> (WV - rm));
        ror_v   = (x >> rm) | (x << (WV - rm));
        asl_hi  = '0;
        asl_lm  = '0;
        asl_bad = 1'b0;
        if (sh >= WV) begin
            asl_bad = |x;
        end else begin
            asl_hi  = x >> (WV - ONE - sh);
            asl_lm  = ~({W{1'b1}} << (sh + ONE));
            asl_bad = !((asl_hi == '0) || (asl_hi == asl_lm));
        end
    end

    // operation select
    always_comb begin
        res = x;
        st  = 1'b0;
        if (op_is_shift(op) && cls.zero) begin
            res = x;
            st  = 1'b0;
        end else begin
            unique case (op)
                OP_LSL: begin
                    res = cls.over ? '0 : lsl_v;
                    st  = cls.over ? 1'b0 : x[i_lsh];
                end
                OP_LSR: begin
                    res = cls.over ? '0 : lsr_v;
                    st  = cls.over ? 1'b0 : x[i_rsh];
                end
                OP_ASL: begin
                    res = lsl_v;
                    st  = asl_bad;
                end
                OP_ASR: begin
                    res = cls.over ? {W{sign}} : asr_v;
                    st  = cls.over ? sign : x[i_rsh];
                end
                OP_ROL: begin
                    res = rol_v;
                    st  = x[i_rol];
                end
                OP_ROR: begin
                    res = ror_v;
                    st  = x[i_ror];
                end
                default: begin
                    res = x;
                    st  = 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        if (op_is_logical(op) && cls.over) begin
            p_logic_over_r4: assert (res == '0 && !st)
                else $error("logical over-range not zero");
        end
        if (op == OP_ASR && cls.over) begin
            p_asr_over_r5: assert (res == {W{x[W-1]}} && st == x[W-1])
                else $error("arith right over-range wrong");
        end
        if (op_is_shift(op) && cls.zero) begin
            p_zero_pass_r9: assert (res == x && !st)
                else $error("zero count altered operand");
        end
        if (op_is_rotate(op)) begin
            p_rot_keep_r8: assert ($countones(res) == $countones(x))
                else $error("rotate lost bits");
        end
        if (op == OP_ASR && !cls.zero) begin
            p_asr_sign_r7: assert (res[W-1] == x[W-1])
                else $error("arith right lost sign");
        end
    end

endmodule

// File: rtl/srf_shift_unit.sv
module srf_shift_unit
    import srf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic              wide_i,
    output logic [DATA_W-1:0] result_o,
    output logic              cl_flag_o
);
    shop_e             op_sel;
    logic [DATA_W-1:0] lane_res [2];
    logic              lane_st  [2];

    assign op_sel = shop_e'(op_i);

    // lane 0 is the narrow (half) width, lane 1 the full width
    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int LANE_W = (g == 0) ? HALF_W : DATA_W;
        logic [LANE_W-1:0] lr;
        logic              ls;

        srf_lane #(.W(LANE_W), .CNT_W(CNT_W)) u_lane (
            .x   (opnd_i[LANE_W-1:0]),
            .cnt (count_i),
            .op  (op_sel),
            .res (lr),
            .st  (ls)
        );

        assign lane_res[g] = DATA_W'(lr);
        assign lane_st[g]  = ls;
    end

    always_comb begin
        result_o  = wide_i ? lane_res[1] : lane_res[0];
        cl_flag_o = wide_i ? lane_st[1]  : lane_st[0];
    end

    always_comb begin
        if (!wide_i) begin
            p_narrow_zext_r10: assert (result_o[DATA_W-1:HALF_W] == '0)
                else $error("narrow result not zero-extended");
        end
        if (op_i == 3'd6 || op_i == 3'd7) begin
            p_reserved_pass_r11: assert (!cl_flag_o)
                else $error("reserved op set flag");
        end
    end

endmodule

// File: tb/sim_srf_shift_unit.sv
module sim_srf_shift_unit;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd;
    logic [7:0]  cnt;
    logic [2:0]  op;
    logic        wide;
    logic [31:0] result;
    logic        flag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    srf_shift_unit u0 (
        .opnd_i    (opnd),
        .count_i   (cnt),
        .op_i      (op),
        .wide_i    (wide),
        .result_o  (result),
        .cl_flag_o (flag)
    );

    // bit-serial reference: one position per step
    function automatic logic [32:0] ref_model(logic [31:0] a, int n, int code, bit wd);
        int          w    = wd ? 32 : 16;
        logic [31:0] mask = wd ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        logic [31:0] v    = a & mask;
        logic        sgn  = v[w-1];
        logic        f    = 1'b0;
        logic        bad  = 1'b0;
        int          m;
        case (code)
            0: for (int i = 0; i < n; i++) begin f = v[w-1]; v = (v << 1) & mask; end
            1: for (int i = 0; i < n; i++) begin f = v[0]; v = v >> 1; end
            2: begin
                for (int i = 0; i < n; i++) begin
                    if (v[w-1] != sgn) bad = 1'b1;
                    v = (v << 1) & mask;
                end
                if (n > 0 && v[w-1] != sgn) bad = 1'b1;
                f = bad;
            end
            3: for (int i = 0; i < n; i++) begin
                f = v[0];
                v = (v >> 1) | (32'(sgn) << (w-1));
            end
            4: begin
                m = (n == 0) ? w : ((n-1) % w) + 1;
                for (int i = 0; i < m; i++) begin
                    f = v[w-1];
                    v = ((v << 1) & mask) | 32'(f);
                end
            end
            5: begin
                m = (n == 0) ? w : ((n-1) % w) + 1;
                for (int i = 0; i < m; i++) begin
                    f = v[0];
                    v = (v >> 1) | (32'(f) << (w-1));
                end
            end
            default: f = 1'b0;
        endcase
        return {f, v};
    endfunction

    function automatic string tag_for(int code, int n, bit wd);
        int w = wd ? 32 : 16;
        if (code >= 6)                return "R11";
        if (code >= 4)                return "R8";
        if (n == 0)                   return "R9";
        if (code == 2)                return "R6";
        if (n > w && code == 3)       return "R5";
        if (n > w)                    return "R4";
        if (code == 0)                return "R3";
        return "R2";
    endfunction

    task automatic apply_check(logic [31:0] a, int n, int code, bit wd, string tag);
        logic [32:0] exp_v;
        @(posedge clk);
        #1;
        opnd = a; cnt = 8'(n); op = 3'(code); wide = wd;
        @(negedge clk);
        exp_v = ref_model(a, n, code, wd);
        n_tests++;
        if (result !== exp_v[31:0] || flag !== exp_v[32]) begin
            n_fail++;
            $display("FAIL %s: op=%0d n=%0d wide=%0d a=%h got res=%h flag=%b exp res=%h flag=%b",
                     tag, code, n, wd, a, result, flag, exp_v[31:0], exp_v[32]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int          s;
        logic [31:0] a;
        int          n, code;
        bit          wd;
        opnd = '0; cnt = '0; op = '0; wide = 1'b0;
        s = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // reset state / zero count
        apply_check(32'h0, 0, 0, 1'b0, "R9");
        // R1: set then clear with the next operation
        apply_check(32'h1, 1, 1, 1'b1, "R1");
        apply_check(32'h0, 1, 1, 1'b1, "R1");
        // R2
        apply_check(32'h0000_0080, 8, 1, 1'b1, "R2");
        apply_check(32'h0000_8000, 16, 3, 1'b0, "R2");
        // R3
        apply_check(32'h0000_4000, 2, 0, 1'b0, "R3");
        apply_check(32'h0000_0001, 16, 0, 1'b0, "R3");
        apply_check(32'h0000_0001, 32, 0, 1'b1, "R3");
        // R4
        apply_check(32'hFFFF_FFFF, 33, 1, 1'b1, "R4");
        apply_check(32'h0000_FFFF, 17, 0, 1'b0, "R4");
        // R5
        apply_check(32'h8000_0001, 40, 3, 1'b1, "R5");
        apply_check(32'h7FFF_FFFF, 200, 3, 1'b1, "R5");
        apply_check(32'h0000_8000, 17, 3, 1'b0, "R5");
        // R6
        apply_check(32'h0000_FFFF, 3, 2, 1'b0, "R6");
        apply_check(32'h0000_4000, 1, 2, 1'b0, "R6");
        apply_check(32'h0000_0001, 20, 2, 1'b0, "R6");
        apply_check(32'h0000_0000, 20, 2, 1'b0, "R6");
        apply_check(32'hFFFF_FFFF, 31, 2, 1'b1, "R6");
        // R7
        apply_check(32'h8000_0000, 4, 3, 1'b1, "R7");
        apply_check(32'h8000_0000, 4, 1, 1'b1, "R7");
        // R8
        apply_check(32'h0000_8001, 17, 4, 1'b0, "R8");
        apply_check(32'h8000_0001, 0, 5, 1'b1, "R8");
        apply_check(32'h0000_0003, 33, 5, 1'b1, "R8");
        apply_check(32'h1234_5678, 16, 4, 1'b0, "R8");
        // R9
        apply_check(32'hDEAD_BEEF, 0, 2, 1'b1, "R9");
        // R10: upper half ignored in narrow mode
        apply_check(32'hABCD_0F0F, 4, 0, 1'b0, "R10");
        apply_check(32'hFFFF_0001, 3, 5, 1'b0, "R10");
        // R11
        apply_check(32'hCAFE_F00D, 5, 6, 1'b1, "R11");
        apply_check(32'hCAFE_F00D, 5, 7, 1'b0, "R11");

        for (int k = 0; k < N_RANDOM; k++) begin
            a    = $urandom;
            if ($urandom_range(0, 3) == 0)
                a = $urandom_range(0, 1) ? (32'hFFFF_FFF0 | ($urandom & 32'hF)) : ($urandom & 32'hF);
            code = $urandom_range(0, 7);
            n    = $urandom_range(0, 1) ? $urandom_range(0, 40) : $urandom_range(0, 255);
            wd   = 1'($urandom_range(0, 1));
            apply_check(a, n, code, wd, tag_for(code, n, wd));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule